// File: doc/BRIEF.md
# Per-Line Edge/Level Interrupt Request Capture

This block samples a bank of interrupt request lines once per clock and keeps one pending-request bit per line. A trigger-mode register sets how each line is sensed. A line in level mode has a pending bit that follows the line. A line in edge mode latches a request on a rising edge and holds it until an acknowledge clears it. The block keeps a last-seen copy of every input, and it compares each input against that copy to find edges.

Software writes the trigger-mode register in one cycle and reads it back at a port. The register stores only the bits that the instance's fixed writability mask allows. Two pulse vectors report each request that is newly latched. One covers unmasked lines and the other covers masked lines, where the request is reported as suppressed. An acknowledge strobe with a line index retires one edge request. An initialize strobe wipes all pending and last-seen state.

All control pins are plain single-cycle strobes. There is no valid/ready handshake, because every write, acknowledge and initialize is taken in the cycle it is presented, so no back-pressure exists. Inputs are assumed to be synchronous to `clk`.

Top module: `irqcap_top`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level) has a pending bit equal to the input sampled at the previous clock edge. A high input sets the bit and a low input clears it.
- R2: A line whose trigger-mode bit is 0 (edge) sets its pending bit on the clock edge where the input is high and the last-seen copy is low.
- R3: On an edge-mode line, a low input clears only the last-seen copy. The pending bit stays set until it is acknowledged or initialized.
- R4: A trigger-mode write stores `mode_wr_data & WR_MASK`, and `mode_q` shows the result from the next cycle on. Bits outside the mask read 0. The primary setting is WR_MASK=8'hF8 and the secondary setting is 8'hDE.
- R5: An acknowledge with `ack_line`=i clears pending bit i on the next edge only if line i is in edge mode. Level-mode lines ignore the acknowledge and stay pending while their input is high.
- R6: `new_q[i]` (line unmasked) or `supp_q[i]` (`line_mask[i]`=1) pulses for one cycle, and only when pending bit i goes from 0 to 1. A set condition on an already-pending line gives no pulse.
- R7: `init_clr` clears every pending bit and every last-seen bit on the next edge and raises no pulse. The trigger mode is unchanged. A line held high afterwards is therefore seen as a fresh rising edge.
- R8: After reset, all pending bits are 0, all pulses are 0 and the trigger mode is 8'h00, so every line is in edge mode.
- R9: If an edge-mode line is acknowledged in the same cycle as a rising edge, the new request wins and the line stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | LINES | Raw request levels |
| line_mask | input | LINES | 1 = line masked; its new requests appear on supp_q |
| mode_wr_en | input | 1 | Trigger-mode write strobe |
| mode_wr_data | input | LINES | Trigger-mode write value (1 = level) |
| mode_q | output | LINES | Trigger-mode register readback |
| ack_en | input | 1 | Acknowledge strobe |
| ack_line | input | IDXW | Index of the line being acknowledged |
| init_clr | input | 1 | Clears pending and last-seen state |
| pend_q | output | LINES | Pending-request vector |
| new_q | output | LINES | One-cycle pulse: request newly latched, line unmasked |
| supp_q | output | LINES | One-cycle pulse: request newly latched, line masked |

## Verification
The bench builds the main instance with LINES=8 and WR_MASK=8'hF8. With that mask, lines 0 to 2 are stuck in edge mode and lines 3 to 7 can be switched to level mode, so edge and level lines run side by side within one stimulus table. A second instance uses WR_MASK=8'hDE, which shows that a different fixed mask drops bits 0 and 5. That instance is used only for trigger-mode writes and readback.

// File: rtl/irqcap_pkg.sv
package irqcap_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irqcap_mode_reg.sv
module irqcap_mode_reg #(
  parameter int         LINES   = 8,
  parameter logic [LINES-1:0] WR_MASK = 8'hF8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LINES-1:0] wr_data,
  output logic [LINES-1:0] mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (wr_en) mode_q <= wr_data & WR_MASK;
  end

  // R4: a write lands masked on the next cycle
  p_mode_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mode_q == ($past(wr_data) & WR_MASK));

  // R4: register holds without a write
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_q));
endmodule

// File: rtl/irqcap_ack_dec.sv
module irqcap_ack_dec #(
  parameter int LINES = 8,
  localparam int IDXW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic            ack_en,
  input  logic [IDXW-1:0] ack_line,
  output logic [LINES-1:0] ack_hot
);
  always_comb begin
    ack_hot = '0;
    for (int i = 0; i < LINES; i++) begin
      if (ack_en && (ack_line == IDXW'(i))) ack_hot[i] = 1'b1;
    end
  end
endmodule

// File: rtl/irqcap_cell.sv
module irqcap_cell
  import irqcap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_clr,
  input  trig_e mode,
  input  logic line_in,
  input  logic ack_hit,
  input  logic masked,
  output logic pend_q,
  output logic new_q,
  output logic supp_q
);
  logic seen_q;
  logic rise, set_now, fresh, pend_d;

  always_comb begin
    rise    = line_in & ~seen_q;
    set_now = (mode == TRIG_LEVEL) ? line_in : rise;
    if (init_clr)                pend_d = 1'b0;
    else if (mode == TRIG_LEVEL) pend_d = line_in;
    else                         pend_d = rise | (pend_q & ~ack_hit);
    fresh = ~init_clr & set_now & ~pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      pend_q <= 1'b0;
      new_q  <= 1'b0;
      supp_q <= 1'b0;
    end else begin
      seen_q <= init_clr ? 1'b0 : line_in;
      pend_q <= pend_d;
      new_q  <= fresh & ~masked;
      supp_q <= fresh & masked;
    end
  end

  // R1: level line follows its input
  p_level_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_clr && mode == TRIG_LEVEL) |=> pend_q == $past(line_in));

  // R2: rising edge latches on an edge line
  p_edge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_clr && mode == TRIG_EDGE && line_in && !seen_q) |=> pend_q);

  // R3: edge request survives a low input
  p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_clr && mode == TRIG_EDGE && pend_q && !ack_hit) |=> pend_q);

  // R5: acknowledge retires an edge request
  p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_clr && mode == TRIG_EDGE && ack_hit && !(line_in && !seen_q)) |=> !pend_q);

  // R6: no pulse for a line already pending
  p_no_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !new_q && !supp_q);

  // R6: a pulse always comes with a pending bit
  p_pulse_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (new_q || supp_q) |-> pend_q);

  // R7: initialize wipes state
  p_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> !pend_q && !new_q && !supp_q);
endmodule

// File: rtl/irqcap_top.sv
module irqcap_top
  import irqcap_pkg::*;
#(
  parameter int         LINES   = 8,
  parameter logic [LINES-1:0] WR_MASK = 8'hF8,
  localparam int IDXW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  input  logic [LINES-1:0] line_mask,
  input  logic             mode_wr_en,
  input  logic [LINES-1:0] mode_wr_data,
  output logic [LINES-1:0] mode_q,
  input  logic             ack_en,
  input  logic [IDXW-1:0]  ack_line,
  input  logic             init_clr,
  output logic [LINES-1:0] pend_q,
  output logic [LINES-1:0] new_q,
  output logic [LINES-1:0] supp_q
);
  logic [LINES-1:0] ack_hot;

  irqcap_mode_reg #(.LINES(LINES), .WR_MASK(WR_MASK)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(mode_wr_en),
    .wr_data(mode_wr_data), .mode_q(mode_q)
  );

  irqcap_ack_dec #(.LINES(LINES)) u_ack (
    .ack_en(ack_en), .ack_line(ack_line), .ack_hot(ack_hot)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    irqcap_cell u_cell (
      .clk(clk), .rst_n(rst_n), .init_clr(init_clr),
      .mode(trig_e'(mode_q[g])), .line_in(line_in[g]),
      .ack_hit(ack_hot[g]), .masked(line_mask[g]),
      .pend_q(pend_q[g]), .new_q(new_q[g]), .supp_q(supp_q[g])
    );
  end

  // R6: a line reports either new or suppressed, never both
  p_flag_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (new_q & supp_q) == '0);

  // R8: reset leaves mode all-edge
  p_reset_mode_r8: assert property (@(posedge clk)
    $rose(rst_n) |-> mode_q == '0);
endmodule

// File: tb/sim_irqcap_top.sv
module sim_irqcap_top;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic       wr;
    logic [7:0] wdata;
    logic [7:0] lines;
    logic [7:0] mask;
    logic       ackv;
    logic [2:0] ackidx;
    logic       init;
    logic [7:0] epend;
    logic [7:0] enew;
    logic [7:0] esup;
    logic [7:0] emode;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b0,8'h00,8'h01,8'h00,1'b0,3'd0,1'b0, 8'h01,8'h01,8'h00,8'h00}, // R2 rise line0
    '{1'b0,8'h00,8'h01,8'h00,1'b0,3'd0,1'b0, 8'h01,8'h00,8'h00,8'h00}, // R6 held high
    '{1'b0,8'h00,8'h00,8'h00,1'b0,3'd0,1'b0, 8'h01,8'h00,8'h00,8'h00}, // R3 low keeps
    '{1'b0,8'h00,8'h01,8'h00,1'b0,3'd0,1'b0, 8'h01,8'h00,8'h00,8'h00}, // R6 rise while pending
    '{1'b0,8'h00,8'h00,8'h00,1'b1,3'd0,1'b0, 8'h00,8'h00,8'h00,8'h00}, // R5 ack edge
    '{1'b1,8'hFF,8'h00,8'h00,1'b0,3'd0,1'b0, 8'h00,8'h00,8'h00,8'hF8}, // R4 masked write
    '{1'b0,8'h00,8'h08,8'h00,1'b0,3'd0,1'b0, 8'h08,8'h08,8'h00,8'hF8}, // R1 level high
    '{1'b0,8'h00,8'h08,8'h00,1'b1,3'd3,1'b0, 8'h08,8'h00,8'h00,8'hF8}, // R5 ack level ignored
    '{1'b0,8'h00,8'h00,8'h00,1'b0,3'd0,1'b0, 8'h00,8'h00,8'h00,8'hF8}, // R1 level drop
    '{1'b0,8'h00,8'h02,8'h02,1'b0,3'd0,1'b0, 8'h02,8'h00,8'h02,8'hF8}, // R6 suppressed
    '{1'b0,8'h00,8'h12,8'h02,1'b0,3'd0,1'b0, 8'h12,8'h10,8'h00,8'hF8}, // R1 R6 level new
    '{1'b0,8'h00,8'h12,8'h00,1'b0,3'd0,1'b1, 8'h00,8'h00,8'h00,8'hF8}, // R7 init
    '{1'b0,8'h00,8'h12,8'h00,1'b0,3'd0,1'b0, 8'h12,8'h12,8'h00,8'hF8}, // R7 fresh after init
    '{1'b0,8'h00,8'h10,8'h00,1'b1,3'd1,1'b0, 8'h10,8'h00,8'h00,8'hF8}, // R5 ack line1
    '{1'b0,8'h00,8'h12,8'h00,1'b1,3'd1,1'b0, 8'h12,8'h02,8'h00,8'hF8}  // R9 ack vs rise
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] line_in = '0, line_mask = '0, mode_wr_data = '0;
  logic mode_wr_en = 1'b0, ack_en = 1'b0, init_clr = 1'b0;
  logic [2:0] ack_line = '0;
  logic [7:0] mode_q, pend_q, new_q, supp_q;
  logic b_wr = 1'b0;
  logic [7:0] b_data = '0;
  logic [7:0] b_mode, b_pend, b_new, b_supp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  irqcap_top #(.LINES(8), .WR_MASK(8'hF8)) u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_mask(line_mask),
    .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data), .mode_q(mode_q),
    .ack_en(ack_en), .ack_line(ack_line), .init_clr(init_clr),
    .pend_q(pend_q), .new_q(new_q), .supp_q(supp_q)
  );

  irqcap_top #(.LINES(8), .WR_MASK(8'hDE)) u1 (
    .clk(clk), .rst_n(rst_n), .line_in(8'h00), .line_mask(8'h00),
    .mode_wr_en(b_wr), .mode_wr_data(b_data), .mode_q(b_mode),
    .ack_en(1'b0), .ack_line(3'd0), .init_clr(1'b0),
    .pend_q(b_pend), .new_q(b_new), .supp_q(b_supp)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 pend", pend_q, 8'h00);
    check("R8 mode", mode_q, 8'h00);
    check("R8 new", new_q | supp_q, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 pend after release", pend_q, 8'h00);

    for (int k = 0; k < NV; k++) begin
      mode_wr_en   = TBL[k].wr;
      mode_wr_data = TBL[k].wdata;
      line_in      = TBL[k].lines;
      line_mask    = TBL[k].mask;
      ack_en       = TBL[k].ackv;
      ack_line     = TBL[k].ackidx;
      init_clr     = TBL[k].init;
      @(posedge clk);
      @(negedge clk);
      check($sformatf("vec%0d pend R1/R2/R3/R5/R7/R9", k), pend_q, TBL[k].epend);
      check($sformatf("vec%0d new R6", k), new_q, TBL[k].enew);
      check($sformatf("vec%0d supp R6", k), supp_q, TBL[k].esup);
      check($sformatf("vec%0d mode R4", k), mode_q, TBL[k].emode);
    end
    mode_wr_en = 1'b0; ack_en = 1'b0; init_clr = 1'b0;

    // R4 write of unwritable bits only on u0
    mode_wr_en = 1'b1; mode_wr_data = 8'h07;
    @(posedge clk); @(negedge clk);
    mode_wr_en = 1'b0;
    check("R4 low bits not writable", mode_q, 8'h00);

    // R4 secondary mask
    b_wr = 1'b1; b_data = 8'hFF;
    @(posedge clk); @(negedge clk);
    check("R4 secondary FF", b_mode, 8'hDE);
    b_data = 8'h21;
    @(posedge clk); @(negedge clk);
    b_wr = 1'b0;
    check("R4 secondary 21", b_mode, 8'h00);

    // R7 init keeps mode: set level, init, mode unchanged
    mode_wr_en = 1'b1; mode_wr_data = 8'h80;
    @(posedge clk); @(negedge clk);
    mode_wr_en = 1'b0; init_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    init_clr = 1'b0;
    check("R7 mode kept", mode_q, 8'h80);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule